// File: doc/BRIEF.md
# Serial Link Frame Controller

This block is the controller end of a five-wire serial audio and modem link. The codec supplies the bit clock. From that clock the block counts frames of 256 bit periods and drives the frame marker, `sync_o`. The marker is high for the 16-bit tag slot at the start of each frame and low for the other 240 periods, so it is not a square wave. At a 12.288 MHz bit clock this gives a 48 kHz frame rate.

On the outbound side, a 256-bit word from the host is latched at each frame boundary. It is shifted out MSB first, and each bit is launched on a rising bit-clock edge. On the inbound side, the line is sampled on the falling edge inside each bit period. The 256 captured bits are handed to the host as one parallel word, with a one-cycle done pulse.

The first inbound bit of a frame is the codec's ready flag. While that flag has not been seen, the block accepts no inbound frames and holds the outbound data line low. It does not decode slot contents.

Top module: `aclink_frame_ctrl`

## Requirements
- R1: A frame lasts exactly 256 bit-clock periods, and `sync_o` rises at the start of every frame.
- R2: `sync_o` is high for bit periods 0 to 15 of each frame and low for periods 16 to 255. The first period starts at the first rising edge after reset is released.
- R3: Outbound bits go out MSB first. In bit period k, `sdata_o` carries bit 255-k of the latched outbound word, changing on the rising edge that starts the period.
- R4: The inbound line is sampled on the falling edge within each bit period. The bit sampled in period k lands in bit 255-k of `rx_frame_o`.
- R5: `tx_frame_i` is latched only on the rising edge that starts a frame. Changes to it during a frame do not affect the bits sent in that frame.
- R6: The codec-ready flag is bit 255 of the inbound frame, sampled in period 0. It is taken over at the end of that frame. `codec_ready_o` shows the flag from the last completed frame and is 0 after reset.
- R7: While `codec_ready_o` is 0 for a frame, `sdata_o` stays 0 for that whole frame.
- R8: For a completed inbound frame whose ready flag is 1, `frame_done_o` is high for exactly one cycle, period 0 of the next frame. `rx_frame_o` takes the new word on that same edge. Frames with the flag at 0 leave `rx_frame_o` unchanged and raise no pulse.
- R9: While `rst_ni` is low, `sync_o`, `sdata_o`, `frame_done_o` and `codec_ready_o` are 0 and `rx_frame_o` is all zeros. A reset in the middle of a frame also clears the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock from the codec |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Inbound serial data |
| tx_frame_i | input | 256 | Outbound frame word from the host |
| sync_o | output | 1 | Frame marker |
| sdata_o | output | 1 | Outbound serial data |
| rx_frame_o | output | 256 | Last accepted inbound frame |
| frame_done_o | output | 1 | One-cycle pulse when a new inbound frame is accepted |
| codec_ready_o | output | 1 | Codec-ready flag from the last completed frame |

## Verification
The hardest case to reach is the handover at the frame boundary. On that one rising edge, the ready flag from the previous frame decides whether the freshly latched outbound word reaches the line, whether the done pulse fires, and whether the inbound word is published. The table drives frames whose tag MSB alternates between 0 and 1, so every transition into and out of the ready state crosses a boundary, and every bit of both directions is checked on each frame. Within each frame the host word is set to its complement and then restored, which shows that only the boundary latch matters. A reset in the middle of a frame, with the codec still signalling ready, confirms that the next frame is sent silent.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned FRAME_BITS_DEF = 256;
  localparam int unsigned TAG_BITS_DEF   = 16;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS_DEF,
  parameter int unsigned TAG_BITS   = aclink_pkg::TAG_BITS_DEF,
  localparam int unsigned PW        = $clog2(FRAME_BITS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wrap_o,
  output logic run_o,
  output logic pos0_o,
  output logic sync_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] TAGN = PW'(TAG_BITS);

  logic [PW-1:0] pos_q, pos_d;
  logic          run_q, sync_q;

  assign wrap_o = (pos_q == LAST);
  assign pos_d  = wrap_o ? '0 : pos_q + 1'b1;

  // pos starts at LAST so the first edge after reset opens frame period 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= LAST;
      run_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      run_q  <= 1'b1;
      sync_q <= (pos_d < TAGN);
    end
  end

  assign run_o  = run_q;
  assign pos0_o = run_q && (pos_q == '0);
  assign sync_o = sync_q;
endmodule

// File: rtl/aclink_tx_shift.sv
module aclink_tx_shift #(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  en_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  sdata_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic                  sdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      sdata_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= {frame_i[FRAME_BITS-2:0], 1'b0};
      sdata_q <= frame_i[FRAME_BITS-1] & en_i;
    end else begin
      sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
      sdata_q <= sh_q[FRAME_BITS-1] & en_i;
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/aclink_rx_capture.sv
module aclink_rx_capture #(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  pos0_i,
  input  logic                  sdata_i,
  input  logic                  publish_i,
  output logic                  tag_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  logic [FRAME_BITS-1:0] sh_q, frame_q;
  logic                  tag_q;

  // falling-edge sampling, half a period after launch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      tag_q <= 1'b0;
    end else if (run_i) begin
      sh_q <= {sh_q[FRAME_BITS-2:0], sdata_i};
      if (pos0_i) tag_q <= sdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frame_q <= '0;
    else if (publish_i) frame_q <= sh_q;
  end

  assign tag_o   = tag_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/aclink_frame_ctrl.sv
module aclink_frame_ctrl #(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS_DEF,
  parameter int unsigned TAG_BITS   = aclink_pkg::TAG_BITS_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sdata_i,
  input  logic [FRAME_BITS-1:0] tx_frame_i,
  output logic                  sync_o,
  output logic                  sdata_o,
  output logic [FRAME_BITS-1:0] rx_frame_o,
  output logic                  frame_done_o,
  output logic                  codec_ready_o
);
  logic wrap, run, pos0, tag, boundary, ready_d, publish;
  logic ready_q, done_q;

  aclink_frame_timer #(.FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_o(wrap),
    .run_o (run),
    .pos0_o(pos0),
    .sync_o(sync_o)
  );

  // an inbound frame completes only on a wrap after the first one
  assign boundary = wrap && run;
  assign ready_d  = boundary ? tag : ready_q;
  assign publish  = boundary && tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      done_q  <= publish;
    end
  end

  aclink_tx_shift #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .en_i   (ready_d),
    .frame_i(tx_frame_i),
    .sdata_o(sdata_o)
  );

  aclink_rx_capture #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .pos0_i   (pos0),
    .sdata_i  (sdata_i),
    .publish_i(publish),
    .tag_o    (tag),
    .frame_o  (rx_frame_o)
  );

  assign frame_done_o  = done_q;
  assign codec_ready_o = ready_q;
endmodule

// File: rtl/aclink_frame_ctrl_chk.sv
module aclink_frame_ctrl_chk #(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS_DEF,
  parameter int unsigned TAG_BITS   = aclink_pkg::TAG_BITS_DEF,
  localparam int unsigned PW        = $clog2(FRAME_BITS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sync_o,
  input logic                  sdata_o,
  input logic [FRAME_BITS-1:0] rx_frame_o,
  input logic                  frame_done_o,
  input logic                  codec_ready_o
);
  logic [PW-1:0] cyc_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      seen_q <= 1'b0;
    end else if (sync_o && !seen_q) begin
      cyc_q  <= '0;
      seen_q <= 1'b1;
    end else if ($rose(sync_o)) begin
      cyc_q  <= '0;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  // R1
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(sync_o)) |-> (int'(cyc_q) == FRAME_BITS - 1));

  // R2
  sync_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$rose(sync_o)) |-> (sync_o == ((int'(cyc_q) + 1) < TAG_BITS)));

  // R7
  silent_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !codec_ready_o |-> !sdata_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R8
  done_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ($rose(sync_o) && codec_ready_o));

  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_o |-> $stable(rx_frame_o));
endmodule

bind aclink_frame_ctrl aclink_frame_ctrl_chk #(
  .FRAME_BITS(FRAME_BITS),
  .TAG_BITS  (TAG_BITS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_o       (sync_o),
  .sdata_o      (sdata_o),
  .rx_frame_o   (rx_frame_o),
  .frame_done_o (frame_done_o),
  .codec_ready_o(codec_ready_o)
);

// File: tb/aclink_frame_ctrl_test.sv
module aclink_frame_ctrl_test;
  localparam int FB = 256;
  localparam int NV = 6;
  // {codec ready flag, inbound seed, outbound seed}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'hA5C3_0F1E, 32'h1234_5678},
    {1'b1, 32'h3C3C_9A01, 32'hDEAD_BEEF},
    {1'b1, 32'hF00D_5A5A, 32'h8000_0001},
    {1'b0, 32'h0123_4567, 32'hFFFF_0000},
    {1'b1, 32'h7E81_C3AA, 32'h5555_AAAA},
    {1'b1, 32'hCAFE_0042, 32'hC001_D00D}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sdata_i = 1'b0;
  logic [FB-1:0] tx_frame_i = '0;
  logic          sync_o, sdata_o, frame_done_o, codec_ready_o;
  logic [FB-1:0] rx_frame_o;

  int checks = 0;
  int fails  = 0;

  logic [FB-1:0] cur_tx, exp_rx;
  logic          exp_en, exp_done;

  always #5 clk_i = ~clk_i;

  aclink_frame_ctrl uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sdata_i      (sdata_i),
    .tx_frame_i   (tx_frame_i),
    .sync_o       (sync_o),
    .sdata_o      (sdata_o),
    .rx_frame_o   (rx_frame_o),
    .frame_done_o (frame_done_o),
    .codec_ready_o(codec_ready_o)
  );

  function automatic logic [FB-1:0] rep(input logic [31:0] s);
    return {8{s}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // checks made in period 0 of a frame about the frame that just ended
  task automatic chk_boundary();
    chk(frame_done_o == exp_done, "R8 done pulse", FB'(frame_done_o), FB'(exp_done));
    chk(rx_frame_o == exp_rx, "R4/R8 inbound word", rx_frame_o, exp_rx);
    chk(codec_ready_o == exp_en, "R6 ready flag", FB'(codec_ready_o), FB'(exp_en));
  endtask

  // entered #2 after the edge that opens period 0; leaves at the same point of the next frame
  task automatic do_frame(input logic [FB-1:0] rx_pat, input logic [FB-1:0] next_tx);
    for (int k = 0; k < FB; k++) begin
      if (k > 0) begin
        @(posedge clk_i);
        #2;
      end
      if (k == 0) chk_boundary();
      if (k == 1) chk(frame_done_o == 1'b0, "R8 single cycle", FB'(frame_done_o), '0);
      chk(sync_o == (k < 16), "R1/R2 sync shape", FB'(sync_o), FB'(k < 16));
      chk(sdata_o == (exp_en & cur_tx[FB-1-k]), "R3/R7 outbound bit",
          FB'(sdata_o), FB'(exp_en & cur_tx[FB-1-k]));
      sdata_i = rx_pat[FB-1-k];
      if (k == 0)   tx_frame_i = ~next_tx; // R5 mid-frame noise
      if (k == 200) tx_frame_i = next_tx;
    end
    @(posedge clk_i);
    #2;
    exp_done = rx_pat[FB-1];
    if (rx_pat[FB-1]) exp_rx = rx_pat;
    exp_en = rx_pat[FB-1];
    cur_tx = next_tx;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tx_frame_i = rep(32'h0BAD_F00D);
    #2;
    // R9 reset state
    chk(sync_o == 0 && sdata_o == 0 && frame_done_o == 0 && codec_ready_o == 0,
        "R9 reset outputs", FB'({sync_o, sdata_o, frame_done_o, codec_ready_o}), '0);
    chk(rx_frame_o == '0, "R9 reset inbound word", rx_frame_o, '0);
    #10 rst_ni = 1'b1;
    cur_tx   = tx_frame_i;
    exp_en   = 1'b0;
    exp_done = 1'b0;
    exp_rx   = '0;
    @(posedge clk_i);
    #2;

    // table walk; boundary checks cover R4, R5, R6, R8 across ready transitions
    for (int i = 0; i < NV; i++) begin
      do_frame({VEC[i][64], rep(VEC[i][63:32])[FB-2:0]}, rep(VEC[i][31:0]));
    end
    chk_boundary();

    // R9 reset mid-frame while the codec is ready
    repeat (40) @(posedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    chk(sync_o == 0 && sdata_o == 0 && frame_done_o == 0 && codec_ready_o == 0,
        "R9 mid-frame reset outputs", FB'({sync_o, sdata_o, frame_done_o, codec_ready_o}), '0);
    chk(rx_frame_o == '0, "R9 mid-frame reset inbound word", rx_frame_o, '0);
    tx_frame_i = rep(32'h9999_6666);
    @(posedge clk_i);
    #3 rst_ni = 1'b1;
    cur_tx   = tx_frame_i;
    exp_en   = 1'b0;
    exp_done = 1'b0;
    exp_rx   = '0;
    @(posedge clk_i);
    #2;
    // R7 first frame after reset is silent despite ready codec
    do_frame({1'b1, rep(32'h1357_9BDF)[FB-2:0]}, rep(32'h2468_ACE0));
    do_frame({1'b1, rep(32'hFEDC_BA98)[FB-2:0]}, rep(32'h0F0F_F0F0));
    chk_boundary();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule